// File: doc/BRIEF.md
# Indirect Flash Read Engine

This block moves a run of bytes from a serial flash into a small word-wide buffer that the host empties at its own pace. The host programs a start address, a byte count, a read opcode, the address width, the data lane mode, an optional mode byte and a dummy-cycle count. It then pulses `start`. The engine opens a frame and shifts out the command. It collects the returned bytes, packs them four to a 32-bit word and pushes each word into the buffer. The buffer occupancy is reported in words.

The serial side is a per-cycle shift interface. While `cs_active` is high, every cycle with `sclk_en` high is one serial clock. In such a cycle the engine drives `so_bit` and samples `si_lanes` on the rising edge.

The sequencer has five states:
- IDLE waits for a start.
- CMD shifts out the opcode, the address and the optional mode byte.
- DUMMY counts idle serial cycles.
- DATA receives bits.
- PUSH hands a finished word to the buffer.

The transitions are:
- Start: IDLE to CMD.
- Command end: CMD to DUMMY, or CMD to DATA when the dummy count is zero.
- Dummy end: DUMMY to DATA.
- Word complete: DATA to PUSH.
- Word stored: PUSH to DATA.
- Transfer complete: PUSH to IDLE.
- Abort: any state to IDLE on `cancel`.

Top module: `fir_indirect_read`

## Requirements
- R1: A `start` pulse while idle, with a nonzero `byte_count`, raises `busy` and `cs_active` on the next cycle. A `start` while `busy` is high has no effect on the running transfer.
- R2: In the command phase `so_bit` carries, one bit per `sclk_en` cycle and MSB first, the opcode, then the address, then `mode_val` if `mode_en` is set. An `addr_width` value of 3 sends four address bytes (`start_addr[31:0]`). Any other value sends three address bytes (`start_addr[23:0]`).
- R3: After the command, exactly `dummy_cycles` further `sclk_en` cycles occur with `so_bit` low, before data begins.
- R4: With `quad_en` low, each data byte is received MSB first on `si_lanes[1]`, one bit per cycle, over 8 cycles. The other lanes are ignored. With `quad_en` high, each byte takes 2 cycles, high nibble first, from `si_lanes[3:0]`.
- R5: Received bytes fill a word from bits [7:0] upward. When `byte_count` is not a multiple of 4, the final word has its unused upper bytes set to zero.
- R6: `buf_level` gives the number of stored words. `buf_word` shows the oldest word. `buf_pop` removes that word, and has no effect when the buffer is empty.
- R7: When the buffer is full and a word is waiting, `sclk_en` stays low and `cs_active` stays high until space frees. No word is lost or reordered.
- R8: When the last word is stored, `busy` and `cs_active` fall and `done` rises on the same edge.
- R9: `done` is cleared by a `done_clr` pulse. Completion in the same cycle as `done_clr` leaves `done` set. `start` does not change `done`.
- R10: A `cancel` pulse, in any state, makes `busy` and `cs_active` low and `buf_level` zero on the next cycle, and does not set `done`. `cancel` wins over a simultaneous `start`.
- R11: A `start` pulse while idle with `byte_count` zero sets `done` on the next cycle without opening a frame.
- R12: `sclk_en` is never high while `cs_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (pulse) |
| cancel | input | 1 | Abort and flush (pulse) |
| done_clr | input | 1 | Write-one-to-clear for `done` |
| start_addr | input | 32 | Flash start address |
| byte_count | input | 16 | Number of bytes to read |
| opcode | input | 8 | Read command opcode |
| addr_width | input | 2 | Address bytes minus one (3 gives four bytes, else three) |
| quad_en | input | 1 | Receive data on four lanes |
| mode_en | input | 1 | Send the mode byte after the address |
| mode_val | input | 8 | Mode byte value |
| dummy_cycles | input | 5 | Idle serial cycles before data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Completion flag |
| cs_active | output | 1 | Serial frame select active |
| sclk_en | output | 1 | One serial clock this cycle |
| so_bit | output | 1 | Serial command output bit |
| si_lanes | input | 4 | Serial input lanes, sampled when `sclk_en` is high |
| buf_pop | input | 1 | Remove the head word |
| buf_word | output | 32 | Head word of the buffer |
| buf_level | output | 16 | Buffer fill level in words |

## Verification
A wrong bit counter or a wrong state transition in the sequencer changes the `sclk_en` pattern or the `so_bit` value within the same frame. The bench compares both against a reference stream on every clock, so such a fault is caught in the first cycle it occurs. A wrong lane choice, a wrong nibble order or a packing error shows up as a wrong `buf_word` at the next pop. A fill-level or stall fault shows up immediately as a `buf_level` difference, or as an `sclk_en` pulse while the buffer is full. A fault in the done, cancel or flush logic shows up on `done`, `busy` or `buf_level` one cycle after the triggering pulse.

// File: rtl/fir_pkg.sv
package fir_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMD   = 3'd1,
        ST_DUMMY = 3'd2,
        ST_DATA  = 3'd3,
        ST_PUSH  = 3'd4
    } fir_state_t;

    localparam int WORD_W   = 32;
    localparam int CMD_VEC_W = 48;
    localparam int BITCNT_W = 6;

endpackage

// File: rtl/fir_word_fifo.sv
module fir_word_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 32,
    parameter int LVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] data_o,
    output logic             full_o,
    output logic [LVL_W-1:0] level_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign full_o  = (cnt == CW'(DEPTH));
    assign do_push = push_i && !full_o && !flush_i;
    assign do_pop  = pop_i && (cnt != '0) && !flush_i;
    assign data_o  = mem[rp];
    assign level_o = LVL_W'(cnt);

    function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush_i) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt_ptr(wp);
            if (do_pop)  rp <= nxt_ptr(rp);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    // R7: the sequencer never offers a word to a full buffer
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    // R6: pop on an empty buffer leaves it empty
    a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !flush_i && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/fir_seq.sv
module fir_seq
    import fir_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cancel_i,
    input  logic              done_clr_i,
    input  logic [31:0]       addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [7:0]        opcode_i,
    input  logic [1:0]        addr_w_i,
    input  logic              quad_i,
    input  logic              mode_en_i,
    input  logic [7:0]        mode_val_i,
    input  logic [4:0]        dummy_i,
    input  logic [3:0]        si_i,
    input  logic              fifo_full_i,
    output logic              push_o,
    output logic [WORD_W-1:0] push_word_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              cs_o,
    output logic              sclk_o,
    output logic              so_o
);
    fir_state_t st, nxt;

    logic [CMD_VEC_W-1:0] shreg, cmd_vec;
    logic [BITCNT_W-1:0]  bit_cnt, cmd_len;
    logic [4:0]           dcnt;
    logic [2:0]           beat;
    logic [1:0]           bidx;
    logic [7:0]           cur_byte, nb;
    logic [WORD_W-1:0]    acc;
    logic [CNT_W-1:0]     left;
    logic                 quad_r;
    logic                 four_b, go, byte_last, word_last, set_fin, set_zero;

    assign four_b    = (addr_w_i == 2'd3);
    assign go        = (st == ST_IDLE) && start_i && !cancel_i && (count_i != '0);
    assign set_zero  = (st == ST_IDLE) && start_i && !cancel_i && (count_i == '0);
    assign set_fin   = (st == ST_PUSH) && !fifo_full_i && (left == '0) && !cancel_i;
    assign byte_last = quad_r ? (beat == 3'd1) : (beat == 3'd7);
    assign word_last = byte_last && ((bidx == 2'd3) || (left == CNT_W'(1)));
    assign nb        = quad_r ? {cur_byte[3:0], si_i} : {cur_byte[6:0], si_i[1]};

    always_comb begin
        if (four_b) cmd_vec = {opcode_i, addr_i, mode_val_i};
        else        cmd_vec = {opcode_i, addr_i[23:0], mode_val_i, 8'h00};
        cmd_len = BITCNT_W'(8) + (four_b ? BITCNT_W'(32) : BITCNT_W'(24))
                + (mode_en_i ? BITCNT_W'(8) : BITCNT_W'(0));
    end

    // next-state
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (go) nxt = ST_CMD;
            ST_CMD:   if (bit_cnt == BITCNT_W'(1)) nxt = (dcnt != '0) ? ST_DUMMY : ST_DATA;
            ST_DUMMY: if (dcnt == 5'd1) nxt = ST_DATA;
            ST_DATA:  if (word_last) nxt = ST_PUSH;
            ST_PUSH:  if (!fifo_full_i) nxt = (left == '0) ? ST_IDLE : ST_DATA;
            default:  nxt = ST_IDLE;
        endcase
        if (cancel_i) nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            dcnt     <= '0;
            beat     <= '0;
            bidx     <= '0;
            cur_byte <= '0;
            acc      <= '0;
            left     <= '0;
            quad_r   <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (go) begin
                        shreg   <= cmd_vec;
                        bit_cnt <= cmd_len;
                        dcnt    <= dummy_i;
                        quad_r  <= quad_i;
                        left    <= count_i;
                        acc     <= '0;
                        bidx    <= '0;
                        beat    <= '0;
                    end
                end
                ST_CMD: begin
                    shreg   <= {shreg[CMD_VEC_W-2:0], 1'b0};
                    bit_cnt <= bit_cnt - 1'b1;
                end
                ST_DUMMY: dcnt <= dcnt - 1'b1;
                ST_DATA: begin
                    cur_byte <= nb;
                    if (byte_last) begin
                        beat <= '0;
                        acc[{bidx, 3'b000} +: 8] <= nb;
                        left <= left - 1'b1;
                        bidx <= bidx + 1'b1;
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
                ST_PUSH: begin
                    if (!fifo_full_i) begin
                        acc  <= '0;
                        bidx <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   done_o <= 1'b0;
        else if (set_fin || set_zero) done_o <= 1'b1;
        else if (done_clr_i)          done_o <= 1'b0;
    end

    // outputs
    always_comb begin
        busy_o      = (st != ST_IDLE);
        cs_o        = (st != ST_IDLE);
        sclk_o      = (st == ST_CMD) || (st == ST_DUMMY) || (st == ST_DATA);
        so_o        = (st == ST_CMD) ? shreg[CMD_VEC_W-1] : 1'b0;
        push_o      = (st == ST_PUSH) && !fifo_full_i;
        push_word_o = acc;
    end

    // R7: a waiting word holds the sequencer while the buffer is full
    a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PUSH && fifo_full_i && !cancel_i) |=> (st == ST_PUSH));

endmodule

// File: rtl/fir_indirect_read.sv
module fir_indirect_read #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 16,
    parameter int LVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cancel,
    input  logic             done_clr,
    input  logic [31:0]      start_addr,
    input  logic [CNT_W-1:0] byte_count,
    input  logic [7:0]       opcode,
    input  logic [1:0]       addr_width,
    input  logic             quad_en,
    input  logic             mode_en,
    input  logic [7:0]       mode_val,
    input  logic [4:0]       dummy_cycles,
    output logic             busy,
    output logic             done,
    output logic             cs_active,
    output logic             sclk_en,
    output logic             so_bit,
    input  logic [3:0]       si_lanes,
    input  logic             buf_pop,
    output logic [31:0]      buf_word,
    output logic [LVL_W-1:0] buf_level
);
    logic        fifo_full, push;
    logic [31:0] push_word;

    fir_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .cancel_i(cancel), .done_clr_i(done_clr),
        .addr_i(start_addr), .count_i(byte_count), .opcode_i(opcode),
        .addr_w_i(addr_width), .quad_i(quad_en), .mode_en_i(mode_en),
        .mode_val_i(mode_val), .dummy_i(dummy_cycles), .si_i(si_lanes),
        .fifo_full_i(fifo_full), .push_o(push), .push_word_o(push_word),
        .busy_o(busy), .done_o(done), .cs_o(cs_active),
        .sclk_o(sclk_en), .so_o(so_bit)
    );

    fir_word_fifo #(.DEPTH(DEPTH), .WIDTH(32), .LVL_W(LVL_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush_i(cancel),
        .push_i(push), .data_i(push_word), .pop_i(buf_pop),
        .data_o(buf_word), .full_o(fifo_full), .level_o(buf_level)
    );

    // R10: cancel empties the buffer and ends the frame
    a_r10_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> (!busy && !cs_active && buf_level == '0));

    // R11: zero-length start completes without a frame
    a_r11_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !cancel && byte_count == '0) |=> (done && !cs_active));

    // R8: a transfer that ends without cancel leaves done set
    a_r8_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(cancel)) |-> done);

    // R12: serial clocks only inside a frame
    a_r12_clk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_en |-> cs_active);

    // R6: level never exceeds the buffer depth
    a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        buf_level <= LVL_W'(DEPTH));

endmodule

// File: tb/fir_indirect_read_test.sv
module fir_indirect_read_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, cancel = 0, done_clr = 0, buf_pop = 0;
    logic [31:0] start_addr = '0;
    logic [15:0] byte_count = '0;
    logic [7:0]  opcode = '0, mode_val = '0;
    logic [1:0]  addr_width = '0;
    logic        quad_en = 0, mode_en = 0;
    logic [4:0]  dummy_cycles = '0;
    logic busy, done, cs_active, sclk_en, so_bit;
    logic [3:0]  si_lanes;
    logic [31:0] buf_word;
    logic [15:0] buf_level;

    always #(CLK_PERIOD/2) clk = ~clk;

    fir_indirect_read #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cancel(cancel), .done_clr(done_clr),
        .start_addr(start_addr), .byte_count(byte_count), .opcode(opcode),
        .addr_width(addr_width), .quad_en(quad_en), .mode_en(mode_en),
        .mode_val(mode_val), .dummy_cycles(dummy_cycles), .busy(busy), .done(done),
        .cs_active(cs_active), .sclk_en(sclk_en), .so_bit(so_bit), .si_lanes(si_lanes),
        .buf_pop(buf_pop), .buf_word(buf_word), .buf_level(buf_level)
    );

    int compared = 0, mismatched = 0;
    bit finished = 0;

    // flash contents as a function of address
    function automatic logic [7:0] fbyte(input logic [31:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    endfunction

    // behavioural flash: counts serial clocks in a frame
    int fcnt = 0, tb_pre = 1000;
    bit tb_quad = 0;
    logic [31:0] tb_addr = '0;

    always @(posedge clk) begin
        if (!cs_active) fcnt <= 0;
        else if (sclk_en) fcnt <= fcnt + 1;
    end

    always_comb begin
        int j;
        logic [7:0] b;
        j = fcnt - tb_pre;
        b = 8'h00;
        si_lanes = 4'b1101;
        if (j >= 0) begin
            if (tb_quad) begin
                b = fbyte(tb_addr + 32'(j / 2));
                si_lanes = ((j % 2) == 0) ? b[7:4] : b[3:0];
            end else begin
                b = fbyte(tb_addr + 32'(j / 8));
                si_lanes = {2'b10, b[7 - (j % 8)], ~b[7 - (j % 8)]};
            end
        end
    end

    // reference model
    bit m_busy = 0, m_done = 0;
    int m_level = 0, m_pre = 0, m_wb = 0, m_left = 0, m_dummy = 0;
    bit exp_so[$];
    logic [31:0] exp_words[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int beats();
        int n;
        n = (m_left > 4) ? 4 : m_left;
        return n * (tb_quad ? 2 : 8);
    endfunction

    task automatic check_all();
        chk("R1 busy", busy, m_busy);
        chk("R8 cs_active", cs_active, m_busy);
        chk("R9 done", done, m_done);
        chk("R6 level", buf_level, m_level);
        chk("R7 sclk_en", sclk_en, m_busy && (m_pre > 0 || m_wb > 0));
        chk("R12 sclk outside frame", sclk_en && !cs_active, 0);
        if (m_busy && m_pre > 0) begin
            if (m_pre <= m_dummy) chk("R3 dummy bit", so_bit, exp_so[0]);
            else                  chk("R2 command bit", so_bit, exp_so[0]);
        end
    endtask

    task automatic begin_xfer();
        int alen;
        alen = (addr_width == 2'd3) ? 4 : 3;
        exp_so.delete();
        for (int i = 7; i >= 0; i--) exp_so.push_back(opcode[i]);
        for (int i = alen * 8 - 1; i >= 0; i--) exp_so.push_back(start_addr[i]);
        if (mode_en) for (int i = 7; i >= 0; i--) exp_so.push_back(mode_val[i]);
        for (int i = 0; i < int'(dummy_cycles); i++) exp_so.push_back(1'b0);
        m_dummy = int'(dummy_cycles);
        m_pre = exp_so.size();
        tb_pre = m_pre; tb_quad = quad_en; tb_addr = start_addr;
        m_left = int'(byte_count); m_busy = 1; m_wb = 0;
        for (int w = 0; w * 4 < int'(byte_count); w++) begin
            logic [31:0] wd;
            wd = '0;
            for (int b = 0; b < 4 && w * 4 + b < int'(byte_count); b++)
                wd[b*8 +: 8] = fbyte(start_addr + 32'(w * 4 + b));
            exp_words.push_back(wd);
        end
    endtask

    task automatic advance(input bit s, input bit c, input bit d, input bit p);
        bit set_done, pushed, popped;
        int lv;
        set_done = 0; pushed = 0; popped = 0; lv = m_level;
        if (c) begin
            m_busy = 0; m_level = 0; m_pre = 0; m_wb = 0;
            exp_words.delete(); tb_pre = 1000;
        end else begin
            popped = p && lv > 0;
            if (m_busy) begin
                if (m_pre > 0) begin
                    m_pre--;
                    void'(exp_so.pop_front());
                    if (m_pre == 0) m_wb = beats();
                end else if (m_wb > 0) begin
                    m_wb--;
                end else if (lv < DEPTH) begin
                    pushed = 1;
                    m_left -= (m_left > 4) ? 4 : m_left;
                    if (m_left == 0) begin m_busy = 0; set_done = 1; end
                    else m_wb = beats();
                end
            end else if (s && byte_count == 0) begin
                set_done = 1;
            end else if (s) begin
                begin_xfer();
            end
            m_level = lv + int'(pushed) - int'(popped);
            if (popped) void'(exp_words.pop_front());
        end
        if (set_done) m_done = 1;
        else if (d)   m_done = 0;
    endtask

    task automatic step(input bit s, input bit c, input bit d, input bit p);
        @(negedge clk);
        check_all();
        if (p && m_level > 0 && !c) chk("R4 R5 word", buf_word, exp_words[0]);
        start = s; cancel = c; done_clr = d; buf_pop = p;
        advance(s, c, d, p);
    endtask

    task automatic run(input bit pe, input bit ce);
        int guard;
        guard = 0;
        while (m_busy && guard < 20000) begin
            step(0, 0, ce, pe && m_level > 0);
            guard++;
        end
        while (m_level > 0) step(0, 0, 0, 1);
    endtask

    task automatic setup(input logic [31:0] a, input int n, input logic [7:0] op,
                         input logic [1:0] aw, input bit q, input bit me,
                         input logic [7:0] mv, input int dm);
        start_addr = a; byte_count = 16'(n); opcode = op; addr_width = aw;
        quad_en = q; mode_en = me; mode_val = mv; dummy_cycles = 5'(dm);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0);
        chk("R8 reset cs_active", cs_active, 0);
        chk("R6 reset level", buf_level, 0);

        // single lane, three address bytes, whole words
        setup(32'h0012_3456, 8, 8'h0B, 2'd2, 0, 0, 8'h00, 0);
        step(1, 0, 0, 0);
        run(1, 0);
        step(0, 0, 1, 0);

        // quad, four address bytes, mode byte, dummy, partial word, start while busy
        setup(32'hA500_0FFD, 7, 8'hEC, 2'd3, 1, 1, 8'hA0, 6);
        step(1, 0, 0, 0);
        repeat (5) step(0, 0, 0, 0);
        step(1, 0, 0, 0);
        run(1, 0);
        step(0, 0, 1, 0);

        // stall on full buffer, then drain
        setup(32'h0000_0100, 24, 8'h03, 2'd0, 0, 0, 8'h00, 2);
        step(1, 0, 0, 0);
        repeat (400) step(0, 0, 0, 0);
        chk("R7 level full during stall", buf_level, DEPTH);
        run(1, 0);
        step(0, 0, 1, 0);

        // cancel mid-transfer
        setup(32'h0000_2000, 40, 8'h6B, 2'd2, 1, 0, 8'h00, 3);
        step(1, 0, 0, 0);
        repeat (60) step(0, 0, 0, 0);
        step(0, 1, 0, 0);
        step(0, 0, 0, 0);
        chk("R10 busy after cancel", busy, 0);
        chk("R10 level after cancel", buf_level, 0);
        chk("R10 done after cancel", done, 0);

        // cancel wins over start
        setup(32'h0000_3000, 4, 8'h0B, 2'd2, 0, 0, 8'h00, 0);
        step(1, 1, 0, 0);
        step(0, 0, 0, 0);
        chk("R10 start with cancel", cs_active, 0);

        // zero-length start
        setup(32'h0000_4000, 0, 8'h0B, 2'd2, 0, 0, 8'h00, 0);
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        chk("R11 zero-length done", done, 1);
        chk("R11 zero-length no frame", cs_active, 0);
        step(0, 0, 1, 0);

        // pop on empty buffer
        step(0, 0, 0, 1);
        step(0, 0, 0, 0);
        chk("R6 empty pop", buf_level, 0);

        // done clear held through completion: set wins
        setup(32'h0000_5001, 1, 8'h13, 2'd3, 0, 1, 8'h5C, 1);
        step(1, 0, 0, 0);
        run(1, 1);
        step(0, 0, 0, 0);
        chk("R9 set wins over clear", done, 1);
        step(0, 0, 1, 0);
        step(0, 0, 0, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog R8: actual busy %0d expected run to end", busy);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule